// File: doc/BRIEF.md
# Reversible 2D Integer Wavelet Engine

This block applies a reversible integer 2D wavelet transform, one to three levels deep, to a square tile of signed coefficients. The tile sits in a single on-chip memory for the whole run. Before a run, the host writes the tile through the load port. It then pulses `start` with a level count and waits for the one-cycle `done` pulse. After that it reads the coefficients back through the read port. Because the arithmetic is integer-only, an inverse lifting pass recovers the original samples bit for bit.

Each level has two passes. The first runs a 5/3 lifting filter along every row of the active region, and the second runs it along every column. Each 1D line is handled in three phases:

- It is fetched into a line buffer.
- It is filtered in place with a predict step followed by an update step. Edges use symmetric extension.
- It is written back de-interleaved, with low-pass results in the first half of the line and high-pass results in the second half.

The active region starts as the full tile and halves in each dimension at every level. Later levels therefore touch only the low-low quadrant left by the previous level.

Top module: `dwt2d_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy` and `done` are both 0.
- R2: While idle, a load write with `ld_we`=1 stores `ld_data` at address row*TILE+col. `rd_data` returns the word at `rd_addr` one clock after the address is presented.
- R3: Every 1D pass computes odd samples as d = x[2n+1] - floor((x[2n]+x[2n+2])/2) and then even samples as s = x[2n] + floor((d[n-1]+d[n]+2)/4). At the edges, a missing right neighbour x[L] is replaced by x[L-2], and d[-1] is replaced by d[0].
- R4: After each 1D pass on a line of length L, the s values occupy positions 0..L/2-1 of that line and the d values occupy positions L/2..L-1. Both keep their order.
- R5: At level j (counting from 0), rows are processed before columns, and only the top-left (TILE>>j)-square is read or written. Coefficients outside that square keep their values.
- R6: `levels` is sampled in the cycle `start` is accepted. A value of 0 runs one level, and values 1..3 run that many levels.
- R7: `busy` is 1 from the cycle after an accepted `start` until the run ends. `done` is high for exactly one cycle, in the first cycle in which `busy` is 0 again.
- R8: A `start` pulse while `busy` is 1 is ignored. It does not change the level count and does not cause a second `done`.
- R9: Load writes while `busy` is 1 are ignored. The finished coefficients are the same as if no write had been made.
- R10: Applying the inverse lifting steps to the coefficients, level by level in reverse order, reconstructs the loaded tile exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Tile load write enable (honoured only while idle) |
| ld_addr | input | 8 | Tile load address, row*TILE+col |
| ld_data | input | 16 | Tile load sample, two's complement |
| start | input | 1 | Begin a transform run (honoured only while idle) |
| levels | input | 2 | Number of decomposition levels; 0 is treated as 1 |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle pulse when the run has finished |
| rd_addr | input | 8 | Coefficient read address (while idle) |
| rd_data | output | 16 | Coefficient at the previous cycle's `rd_addr` |

## Verification
The bench builds the engine with its default parameters: a 16x16 tile, 16-bit coefficients and at most three levels. With these values, line lengths of 16, 8 and 4 all occur, so symmetric extension is exercised on the shortest line as well as on full rows and columns. The bench reaches the full level range, including the level-0 alias, and covers the region that must stay untouched above level one. Sample magnitudes are kept within ±1000 so that no coefficient wraps, which lets an integer model and an exact inverse judge every word of the tile.

// File: rtl/dwt53_pkg.sv
package dwt53_pkg;

  // Per-line sequencing phases of the engine
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_RDW  = 3'd2,
    ST_PRED = 3'd3,
    ST_UPD  = 3'd4,
    ST_WR   = 3'd5
  } eng_state_e;

endpackage

// File: rtl/tile_ram.sv
module tile_ram #(
  parameter int DEPTH = 256,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // One write and one registered read per cycle
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/lift_line.sv
module lift_line #(
  parameter int TILE = 16,
  parameter int W    = 16,
  localparam int IW   = $clog2(TILE),
  localparam int HALF = TILE / 2,
  localparam int XW   = W + 2
) (
  input  logic          clk,
  input  logic          cap_en,
  input  logic [IW-1:0] cap_idx,
  input  logic [W-1:0]  cap_data,
  input  logic          pred_en,
  input  logic          upd_en,
  input  logic [IW-1:0] lenm1,
  input  logic [IW-1:0] out_pos,
  output logic [W-1:0]  out_data
);

  logic signed [W-1:0] line_q [TILE];
  logic signed [W-1:0] pred_v [HALF];
  logic signed [W-1:0] upd_v  [HALF];

  genvar n;
  generate
    for (n = 0; n < HALF; n++) begin : g_pair
      logic signed [W-1:0]  right_s;
      logic signed [W-1:0]  dleft_s;
      logic signed [XW-1:0] lx, rx, cx, ex, dlx, drx;

      // right neighbour of an odd sample, mirrored at the line end
      if (2 * n + 2 < TILE) begin : g_mid
        assign right_s = (IW'(2 * n + 2) <= lenm1) ? line_q[2*n+2] : line_q[2*n];
      end else begin : g_end
        assign right_s = line_q[2*n];
      end

      // left detail of an even sample, mirrored at the line start
      if (n == 0) begin : g_first
        assign dleft_s = line_q[1];
      end else begin : g_rest
        assign dleft_s = line_q[2*n-1];
      end

      assign lx  = line_q[2*n];
      assign rx  = right_s;
      assign cx  = line_q[2*n+1];
      assign ex  = line_q[2*n];
      assign dlx = dleft_s;
      assign drx = line_q[2*n+1];

      assign pred_v[n] = W'(cx - ((lx + rx) >>> 1));
      assign upd_v[n]  = W'(ex + ((dlx + drx + XW'(2)) >>> 2));
    end
  endgenerate

  // line buffer: capture, then predict on odd slots, then update on even slots
  always_ff @(posedge clk) begin
    if (cap_en) begin
      line_q[cap_idx] <= cap_data;
    end
    if (pred_en) begin
      for (int k = 0; k < HALF; k++) begin
        line_q[2*k+1] <= pred_v[k];
      end
    end
    if (upd_en) begin
      for (int k = 0; k < HALF; k++) begin
        line_q[2*k] <= upd_v[k];
      end
    end
  end

  // de-interleave on the way out: low band first, then high band
  logic [IW-1:0] hmask;
  logic          is_hi;
  logic [IW-1:0] src_idx;

  always_comb begin
    hmask   = lenm1 >> 1;
    is_hi   = |(out_pos & ~hmask);
    src_idx = is_hi ? (((out_pos & hmask) << 1) | IW'(1)) : (out_pos << 1);
  end

  assign out_data = line_q[src_idx];

endmodule

// File: rtl/dwt_ctrl.sv
module dwt_ctrl
  import dwt53_pkg::*;
#(
  parameter int TILE       = 16,
  parameter int MAX_LEVELS = 3,
  localparam int IW = $clog2(TILE),
  localparam int AW = 2 * IW,
  localparam int LW = $clog2(MAX_LEVELS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] levels,
  output logic          busy,
  output logic          done,
  output logic [LW-1:0] nlev_o,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW-1:0] mem_raddr,
  output logic          cap_en,
  output logic [IW-1:0] cap_idx,
  output logic          pred_en,
  output logic          upd_en,
  output logic [IW-1:0] lenm1,
  output logic [IW-1:0] out_pos
);

  localparam logic [IW-1:0] MAXI = '1;

  eng_state_e    state_q, state_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic [LW-1:0] nlev_q, nlev_d;
  logic          col_q, col_d;
  logic [IW-1:0] line_q, line_d;
  logic [IW-1:0] pos_q, pos_d;
  logic          capv_q, capv_d;
  logic [IW-1:0] capi_q, capi_d;
  logic          done_q, done_d;

  logic          last_lvl;
  logic [AW-1:0] addr;

  assign lenm1    = MAXI >> lvl_q;
  assign last_lvl = (lvl_q == nlev_q - LW'(1));
  assign addr     = col_q ? {pos_q, line_q} : {line_q, pos_q};

  // next-state process
  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    nlev_d  = nlev_q;
    col_d   = col_q;
    line_d  = line_q;
    pos_d   = pos_q;
    done_d  = 1'b0;
    capv_d  = (state_q == ST_RD);
    capi_d  = pos_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          nlev_d  = (levels == '0) ? LW'(1) : levels;
          lvl_d   = '0;
          col_d   = 1'b0;
          line_d  = '0;
          pos_d   = '0;
          state_d = ST_RD;
        end
      end
      ST_RD: begin
        if (pos_q == lenm1) begin
          pos_d   = '0;
          state_d = ST_RDW;
        end else begin
          pos_d = pos_q + IW'(1);
        end
      end
      ST_RDW:  state_d = ST_PRED;
      ST_PRED: state_d = ST_UPD;
      ST_UPD:  state_d = ST_WR;
      ST_WR: begin
        if (pos_q == lenm1) begin
          pos_d   = '0;
          state_d = ST_RD;
          if (line_q == lenm1) begin
            line_d = '0;
            if (col_q) begin
              if (last_lvl) begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
              end else begin
                lvl_d = lvl_q + LW'(1);
                col_d = 1'b0;
              end
            end else begin
              col_d = 1'b1;
            end
          end else begin
            line_d = line_q + IW'(1);
          end
        end else begin
          pos_d = pos_q + IW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      nlev_q  <= LW'(1);
      col_q   <= 1'b0;
      line_q  <= '0;
      pos_q   <= '0;
      capv_q  <= 1'b0;
      capi_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      nlev_q  <= nlev_d;
      col_q   <= col_d;
      line_q  <= line_d;
      pos_q   <= pos_d;
      capv_q  <= capv_d;
      capi_q  <= capi_d;
      done_q  <= done_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign nlev_o    = nlev_q;
  assign mem_we    = (state_q == ST_WR);
  assign mem_waddr = addr;
  assign mem_raddr = addr;
  assign cap_en    = capv_q;
  assign cap_idx   = capi_q;
  assign pred_en   = (state_q == ST_PRED);
  assign upd_en    = (state_q == ST_UPD);
  assign out_pos   = pos_q;

endmodule

// File: rtl/dwt2d_engine.sv
module dwt2d_engine #(
  parameter int TILE       = 16,
  parameter int W          = 16,
  parameter int MAX_LEVELS = 3,
  localparam int IW = $clog2(TILE),
  localparam int AW = 2 * IW,
  localparam int LW = $clog2(MAX_LEVELS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_data,
  input  logic          start,
  input  logic [LW-1:0] levels,
  output logic          busy,
  output logic          done,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic          eng_we;
  logic [AW-1:0] eng_waddr, eng_raddr;
  logic [W-1:0]  eng_wdata;
  logic          cap_en, pred_en, upd_en;
  logic [IW-1:0] cap_idx, lenm1, out_pos;
  logic [LW-1:0] nlev_w;
  logic [W-1:0]  mem_rdata;

  logic          m_we;
  logic [AW-1:0] m_waddr, m_raddr;
  logic [W-1:0]  m_wdata;

  // the engine owns the memory while busy; the host otherwise
  always_comb begin
    m_we    = busy ? eng_we    : ld_we;
    m_waddr = busy ? eng_waddr : ld_addr;
    m_wdata = busy ? eng_wdata : ld_data;
    m_raddr = busy ? eng_raddr : rd_addr;
  end

  tile_ram #(.DEPTH(TILE * TILE), .W(W)) u_ram (
    .clk   (clk),
    .we    (m_we),
    .waddr (m_waddr),
    .wdata (m_wdata),
    .raddr (m_raddr),
    .rdata (mem_rdata)
  );

  dwt_ctrl #(.TILE(TILE), .MAX_LEVELS(MAX_LEVELS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .levels    (levels),
    .busy      (busy),
    .done      (done),
    .nlev_o    (nlev_w),
    .mem_we    (eng_we),
    .mem_waddr (eng_waddr),
    .mem_raddr (eng_raddr),
    .cap_en    (cap_en),
    .cap_idx   (cap_idx),
    .pred_en   (pred_en),
    .upd_en    (upd_en),
    .lenm1     (lenm1),
    .out_pos   (out_pos)
  );

  lift_line #(.TILE(TILE), .W(W)) u_line (
    .clk      (clk),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .cap_data (mem_rdata),
    .pred_en  (pred_en),
    .upd_en   (upd_en),
    .lenm1    (lenm1),
    .out_pos  (out_pos),
    .out_data (eng_wdata)
  );

  assign rd_data = mem_rdata;

endmodule

// File: rtl/dwt2d_chk.sv
module dwt2d_chk #(
  parameter int LW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [LW-1:0] nlev
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                        // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                        // R7
  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);                                  // R7
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);                             // R7
  AST_LEVELS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(nlev));               // R8
  AST_LEVELS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (nlev != '0));                                 // R6

endmodule

bind dwt2d_engine dwt2d_chk #(.LW(LW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .nlev  (nlev_w)
);

// File: tb/sim_dwt2d_engine.sv
`timescale 1ns/1ps
module sim_dwt2d_engine;

  localparam int TILE = 16;
  localparam int NPIX = TILE * TILE;
  localparam int NC   = 7;
  // stimulus table: levels per case and pattern kind per case
  localparam int CASE_LV  [NC] = '{1, 2, 3, 3, 1, 2, 3};
  localparam int CASE_PAT [NC] = '{0, 1, 2, 3, 4, 5, 1};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ld_we;
  logic [7:0] ld_addr;
  logic [15:0] ld_data;
  logic       start;
  logic [1:0] levels;
  logic       busy, done;
  logic [7:0] rd_addr;
  logic [15:0] rd_data;

  always #4 clk = ~clk;

  dwt2d_engine u0 (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .start(start), .levels(levels), .busy(busy), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int total = 0;
  int bad   = 0;
  int orig [NPIX];
  int mdl  [NPIX];
  int got  [NPIX];
  int rec  [NPIX];

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cmp_arr(input string req, input int a [NPIX], input int e [NPIX]);
    int nmis = 0;
    int first = -1;
    for (int i = 0; i < NPIX; i++) begin
      if (a[i] != e[i]) begin
        nmis++;
        if (first < 0) first = i;
      end
    end
    total++;
    if (nmis != 0) begin
      bad++;
      $display("FAIL %s addr=%0d act=%0d exp=%0d mismatches=%0d",
               req, first, a[first], e[first], nmis);
    end
  endtask

  function automatic int pat(input int kind, input int idx);
    case (kind)
      0: return (idx % TILE) * 13 - (idx / TILE) * 7;
      1: return (((idx % TILE) + (idx / TILE)) % 2 == 0) ? 900 : -900;
      2: return ((idx * 37 + 11) * 73) % 1999 - 999;
      3: return 500;
      4: return (idx == 0) ? 1000 : 0;
      default: return (idx == NPIX - 1) ? -1000 : 0;
    endcase
  endfunction

  task automatic fwd1d(inout int ln [TILE], input int len);
    int x [TILE];
    int r, l;
    x = ln;
    for (int i = 1; i < len; i += 2) begin
      r = (i + 1 < len) ? x[i+1] : x[i-1];
      x[i] = x[i] - ((x[i-1] + r) >>> 1);
    end
    for (int i = 0; i < len; i += 2) begin
      l = (i == 0) ? x[1] : x[i-1];
      x[i] = x[i] + ((l + x[i+1] + 2) >>> 2);
    end
    for (int k = 0; k < len / 2; k++) begin
      ln[k]         = x[2*k];
      ln[k + len/2] = x[2*k+1];
    end
  endtask

  task automatic inv1d(inout int ln [TILE], input int len);
    int x [TILE];
    int r, l;
    x = ln;
    for (int k = 0; k < len / 2; k++) begin
      x[2*k]   = ln[k];
      x[2*k+1] = ln[k + len/2];
    end
    for (int i = 0; i < len; i += 2) begin
      l = (i == 0) ? x[1] : x[i-1];
      x[i] = x[i] - ((l + x[i+1] + 2) >>> 2);
    end
    for (int i = 1; i < len; i += 2) begin
      r = (i + 1 < len) ? x[i+1] : x[i-1];
      x[i] = x[i] + ((x[i-1] + r) >>> 1);
    end
    for (int i = 0; i < len; i++) ln[i] = x[i];
  endtask

  task automatic model_fwd(inout int t [NPIX], input int lv);
    int ln [TILE];
    for (int j = 0; j < lv; j++) begin
      int len = TILE >> j;
      for (int r = 0; r < len; r++) begin
        for (int k = 0; k < len; k++) ln[k] = t[r*TILE+k];
        fwd1d(ln, len);
        for (int k = 0; k < len; k++) t[r*TILE+k] = ln[k];
      end
      for (int c = 0; c < len; c++) begin
        for (int k = 0; k < len; k++) ln[k] = t[k*TILE+c];
        fwd1d(ln, len);
        for (int k = 0; k < len; k++) t[k*TILE+c] = ln[k];
      end
    end
  endtask

  task automatic model_inv(inout int t [NPIX], input int lv);
    int ln [TILE];
    for (int j = lv - 1; j >= 0; j--) begin
      int len = TILE >> j;
      for (int c = 0; c < len; c++) begin
        for (int k = 0; k < len; k++) ln[k] = t[k*TILE+c];
        inv1d(ln, len);
        for (int k = 0; k < len; k++) t[k*TILE+c] = ln[k];
      end
      for (int r = 0; r < len; r++) begin
        for (int k = 0; k < len; k++) ln[k] = t[r*TILE+k];
        inv1d(ln, len);
        for (int k = 0; k < len; k++) t[r*TILE+k] = ln[k];
      end
    end
  endtask

  task automatic load_tile(input int kind);
    for (int a = 0; a < NPIX; a++) begin
      orig[a] = pat(kind, a);
      @(negedge clk);
      ld_we   = 1'b1;
      ld_addr = 8'(a);
      ld_data = 16'(orig[a]);
    end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic read_tile();
    for (int a = 0; a < NPIX; a++) begin
      rd_addr = 8'(a);
      @(negedge clk);
      got[a] = int'($signed(rd_data));
    end
  endtask

  // poke: 0 none, 1 start pulse mid-run, 2 load write mid-run
  task automatic run(input int lv, input int poke, output int ndone);
    int cnt = 0;
    bit seen = 0;
    ndone = 0;
    @(negedge clk);
    start  = 1'b1;
    levels = 2'(lv);
    @(negedge clk);
    start = 1'b0;
    chk("R7 busy after start", int'(busy), 1);
    while (!seen && cnt < 20000) begin
      if (cnt == 50 && poke == 1) begin start = 1'b1; levels = 2'd3; end
      if (cnt == 50 && poke == 2) begin ld_we = 1'b1; ld_addr = 8'd0; ld_data = 16'd12345; end
      @(negedge clk);
      cnt++;
      start = 1'b0;
      ld_we = 1'b0;
      if (done) begin
        ndone++;
        seen = 1;
        chk("R7 busy low in done cycle", int'(busy), 0);
      end
    end
    if (!seen) chk("R7 done timeout", 0, 1);
    repeat (4) begin
      @(negedge clk);
      if (done) ndone++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nd;
    rst_n = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_data = '0;
    start = 1'b0; levels = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);

    // R2: load and raw readback while idle
    load_tile(2);
    rd_addr = 8'd37;
    @(negedge clk);
    chk("R2 readback addr 37", int'($signed(rd_data)), pat(2, 37));
    rd_addr = 8'd200;
    @(negedge clk);
    chk("R2 readback addr 200", int'($signed(rd_data)), pat(2, 200));

    // table walk: R3 R4 R5 coefficients vs model, R10 exact inverse, R7 one pulse
    for (int c = 0; c < NC; c++) begin
      load_tile(CASE_PAT[c]);
      run(CASE_LV[c], 0, nd);
      chk("R7 single done pulse", nd, 1);
      read_tile();
      mdl = orig;
      model_fwd(mdl, CASE_LV[c]);
      cmp_arr("R3 R4 R5 coefficients", got, mdl);
      rec = got;
      model_inv(rec, CASE_LV[c]);
      cmp_arr("R10 inverse reconstruction", rec, orig);
    end

    // R4: constant tile, one level: LL keeps value, high bands are zero
    load_tile(3);
    run(1, 0, nd);
    read_tile();
    chk("R4 LL of constant", got[0], 500);
    chk("R4 HL of constant", got[8], 0);
    chk("R4 LH of constant", got[8*TILE], 0);
    chk("R4 HH of constant", got[8*TILE+8], 0);

    // R5: two levels leave the outer three quadrants as after level one
    load_tile(2);
    run(2, 0, nd);
    read_tile();
    mdl = orig;
    model_fwd(mdl, 1);
    chk("R5 untouched corner", got[NPIX-1], mdl[NPIX-1]);
    chk("R5 untouched HL", got[12], mdl[12]);

    // R6: level count 0 behaves as 1
    load_tile(0);
    run(0, 0, nd);
    read_tile();
    mdl = orig;
    model_fwd(mdl, 1);
    cmp_arr("R6 levels zero as one", got, mdl);

    // R8: start while busy ignored
    load_tile(1);
    run(1, 1, nd);
    chk("R8 no extra done", nd, 1);
    read_tile();
    mdl = orig;
    model_fwd(mdl, 1);
    cmp_arr("R8 levels unchanged", got, mdl);

    // R9: load write while busy ignored
    load_tile(2);
    run(2, 2, nd);
    read_tile();
    mdl = orig;
    model_fwd(mdl, 2);
    cmp_arr("R9 load ignored while busy", got, mdl);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule